// File: doc/BRIEF.md
# Keyboard Command Responder

This block is the keyboard end of a serial keyboard link. The host sends single command bytes. A reset query and a layout query each answer with a fixed run of bytes. A lighting command uses the byte that follows it as its argument, and that byte is ignored. Key events arrive already translated to a 7-bit keycode with a down/up flag. They are sent as make codes (bit 7 clear) or break codes (bit 7 set).

The two lock keys, caps and num, each pass through a two-bit toggle filter. Of each pair of physical presses only the first is sent, and of each pair of releases only the second is sent. The host therefore sees one press when the lock turns on and one release when it turns off. Command replies and key codes share one byte queue, which the consumer reads one byte at a time.

A reply run is written into the queue one byte per clock. While a run is in progress the block reports busy and drops new command bytes. A key event in the same cycle as a reply byte takes the queue write port, and the reply waits one cycle.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, busy is low, the lighting-argument state is clear and both lock filters are back at their initial state.
- R2: An accepted command 0x01 empties the queue in its own cycle and then queues 0xFF, 0x04, 0x7F in that order.
- R3: An accepted command 0x07 or 0x0F empties the queue and then queues 0xFE, 0x21 in that order.
- R4: An accepted command 0x0E queues nothing. The next accepted command byte is discarded whatever its value, and normal decoding then resumes.
- R5: Every other command byte value leaves the queue and busy unchanged.
- R6: A command byte is accepted only while tx_en is high and link_dis is low. A byte presented at any other time has no effect, and it does not use up a pending lighting argument.
- R7: busy rises in the cycle after a reply command is accepted. One reply byte is queued per clock. busy falls in the cycle after the last reply byte is queued. Command bytes presented while busy is high are dropped.
- R8: A key press queues {1'b0, keycode} and a key release queues {1'b1, keycode}, for every keycode that is not a lock key.
- R9: The lock keys (caps 0x77, num 0x62) each hold a 2-bit state. A press XORs bit 0 and is dropped if the result is 2. A release XORs bit 1 and is dropped if the result is 3. The two states are independent.
- R10: When a key event and a pending reply byte meet in the same cycle, the key byte is queued first and the reply continues in the next cycle.
- R11: The queue is first-in first-out with DEPTH entries. A write to a full queue is dropped. A read from an empty queue has no effect. q_data reads 0x00 while the queue is empty.
- R12: A key event in the same cycle as an accepted reply command is queued into the emptied queue, ahead of the reply bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte from host |
| tx_en | input | 1 | Host transmit enable; commands decoded only when high |
| link_dis | input | 1 | Link disable; commands ignored when high |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Translated keycode |
| key_down | input | 1 | 1 = press, 0 = release |
| q_pop | input | 1 | Remove the head byte of the queue |
| q_data | output | 8 | Head byte of the queue, 0x00 when empty |
| q_count | output | $clog2(DEPTH+1) | Number of bytes queued |
| busy | output | 1 | Reply sequence in progress |

## Verification
On every cycle the assertions check the following: the queue never holds more than DEPTH bytes, an empty queue reads zero, the reset state, that busy only rises after an accepted command, that gated command bytes never start a reply, and that a reply start leaves at most one byte queued. The bench scenarios cover the rest: the exact reply contents and their order, the lighting-argument skip, the alternating lock filter sequence, the key-over-reply ordering, and the result of writing to a full queue. Command byte values and non-lock keycodes are swept exhaustively.

// File: rtl/kbdr_pkg.sv
package kbdr_pkg;

    localparam logic [7:0] CMD_RESET  = 8'h01;
    localparam logic [7:0] CMD_LAYOUT = 8'h07;
    localparam logic [7:0] CMD_LAYALT = 8'h0F;
    localparam logic [7:0] CMD_LEDS   = 8'h0E;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_RESET,
        CK_LAYOUT,
        CK_LEDS
    } cmd_kind_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } qpush_t;

    typedef struct packed {
        logic [1:0] next;
        logic       drop;
    } lock_step_t;

    function automatic cmd_kind_e decode_cmd(input logic [7:0] b);
        case (b)
            CMD_RESET:              return CK_RESET;
            CMD_LAYOUT, CMD_LAYALT: return CK_LAYOUT;
            CMD_LEDS:               return CK_LEDS;
            default:                return CK_NONE;
        endcase
    endfunction

    // index of the final byte of a reply run
    function automatic logic [1:0] reply_last(input cmd_kind_e k);
        return (k == CK_RESET) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [7:0] reply_byte(input cmd_kind_e k, input logic [1:0] idx);
        if (k == CK_RESET) begin
            case (idx)
                2'd0:    return 8'hFF;
                2'd1:    return 8'h04;
                default: return 8'h7F;
            endcase
        end
        return (idx == 2'd0) ? 8'hFE : 8'h21;
    endfunction

    function automatic lock_step_t lock_step(input logic [1:0] s, input logic down);
        lock_step_t r;
        r.next = down ? (s ^ 2'b01) : (s ^ 2'b10);
        r.drop = down ? (r.next == 2'd2) : (r.next == 2'd3);
        return r;
    endfunction

endpackage

// File: rtl/kbdr_lock_filter.sv
module kbdr_lock_filter
    import kbdr_pkg::*;
#(
    parameter logic [6:0] CAPS_CODE = 7'h77,
    parameter logic [6:0] NUM_CODE  = 7'h62,
    parameter int         N_LOCKS   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       key_down,
    output qpush_t     key_push
);

    logic [N_LOCKS-1:0] hit;
    logic [N_LOCKS-1:0] drop;

    for (genvar i = 0; i < N_LOCKS; i++) begin : g_lock
        localparam logic [6:0] CODE = (i == 0) ? CAPS_CODE : NUM_CODE;
        logic [1:0] state;
        lock_step_t step;

        always_comb begin
            step    = lock_step(state, key_down);
            hit[i]  = (key_code == CODE);
            drop[i] = hit[i] & step.drop;
        end

        always_ff @(posedge clk) begin
            if (rst)
                state <= 2'd0;
            else if (key_valid && hit[i])
                state <= step.next;
        end
    end

    always_comb begin
        key_push.valid = key_valid && !(|drop);
        key_push.data  = {~key_down, key_code};
    end

endmodule

// File: rtl/kbdr_cmd_seq.sv
module kbdr_cmd_seq
    import kbdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       tx_en,
    input  logic       link_dis,
    input  logic       stall,
    output qpush_t     seq_push,
    output logic       q_clear,
    output logic       busy
);

    cmd_kind_e  kind;
    cmd_kind_e  kind_q;
    logic [1:0] idx;
    logic       led_arg;
    logic       accept;
    logic       starts;

    always_comb begin
        kind          = decode_cmd(cmd_byte);
        accept        = cmd_valid && tx_en && !link_dis && !busy;
        starts        = accept && !led_arg && (kind == CK_RESET || kind == CK_LAYOUT);
        q_clear       = starts;
        seq_push.valid = busy && !stall;
        seq_push.data  = reply_byte(kind_q, idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= CK_RESET;
            idx     <= 2'd0;
            led_arg <= 1'b0;
            busy    <= 1'b0;
        end else begin
            if (accept) begin
                if (led_arg)
                    led_arg <= 1'b0;
                else if (kind == CK_LEDS)
                    led_arg <= 1'b1;
            end
            if (starts) begin
                kind_q <= kind;
                idx    <= 2'd0;
                busy   <= 1'b1;
            end else if (seq_push.valid) begin
                idx <= idx + 2'd1;
                if (idx == reply_last(kind_q))
                    busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/kbdr_byte_queue.sv
module kbdr_byte_queue #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       q_data,
    output logic [CNT_W-1:0] q_count
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic             do_push, do_pop;
    logic [PTR_W-1:0] wr_idx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (clear || q_count < CNT_W'(DEPTH));
        do_pop  = pop && !clear && (q_count != '0);
        wr_idx  = clear ? '0 : wptr;
        q_data  = (q_count != '0) ? mem[rptr] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst && do_push)
            mem[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr    <= '0;
            wptr    <= '0;
            q_count <= '0;
        end else if (clear) begin
            rptr    <= '0;
            wptr    <= do_push ? bump('0) : '0;
            q_count <= do_push ? CNT_W'(1) : '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            q_count <= q_count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
    import kbdr_pkg::*;
#(
    parameter int         DEPTH     = 8,
    parameter logic [6:0] CAPS_CODE = 7'h77,
    parameter logic [6:0] NUM_CODE  = 7'h62,
    localparam int        CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             tx_en,
    input  logic             link_dis,
    input  logic             key_valid,
    input  logic [6:0]       key_code,
    input  logic             key_down,
    input  logic             q_pop,
    output logic [7:0]       q_data,
    output logic [CNT_W-1:0] q_count,
    output logic             busy
);

    qpush_t key_push;
    qpush_t seq_push;
    qpush_t wr;
    logic   q_clear;

    kbdr_lock_filter #(
        .CAPS_CODE(CAPS_CODE),
        .NUM_CODE (NUM_CODE),
        .N_LOCKS  (2)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_valid(key_valid),
        .key_code (key_code),
        .key_down (key_down),
        .key_push (key_push)
    );

    kbdr_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_byte (cmd_byte),
        .tx_en    (tx_en),
        .link_dis (link_dis),
        .stall    (key_push.valid),
        .seq_push (seq_push),
        .q_clear  (q_clear),
        .busy     (busy)
    );

    // key bytes take the write port; the reply stalls that cycle
    always_comb wr = key_push.valid ? key_push : seq_push;

    kbdr_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .clear    (q_clear),
        .push     (wr.valid),
        .push_data(wr.data),
        .pop      (q_pop),
        .q_data   (q_data),
        .q_count  (q_count)
    );

endmodule

// File: rtl/kbdr_checker.sv
module kbdr_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             tx_en,
    input logic             link_dis,
    input logic [7:0]       q_data,
    input logic [CNT_W-1:0] q_count,
    input logic             busy
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_count == '0 && !busy));

    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (q_count <= CNT_W'(1)));

    p_gated_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && (!tx_en || link_dis)) |=> !busy);

    p_busy_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid && tx_en && !link_dis));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_empty_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |-> (q_data == 8'h00));

endmodule

bind kbd_responder kbdr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .tx_en    (tx_en),
    .link_dis (link_dis),
    .q_data   (q_data),
    .q_count  (q_count),
    .busy     (busy)
);

// File: tb/test_kbd_responder.sv
`timescale 1ns/1ps
module test_kbd_responder;

    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_byte = 8'h00;
    logic             tx_en = 1'b1;
    logic             link_dis = 1'b0;
    logic             key_valid = 1'b0;
    logic [6:0]       key_code = 7'h00;
    logic             key_down = 1'b0;
    logic             q_pop = 1'b0;
    logic [7:0]       q_data;
    logic [CNT_W-1:0] q_count;
    logic             busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    kbd_responder #(.DEPTH(DEPTH)) i_kbd_responder (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .tx_en(tx_en), .link_dis(link_dis), .key_valid(key_valid),
        .key_code(key_code), .key_down(key_down), .q_pop(q_pop),
        .q_data(q_data), .q_count(q_count), .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic key(input logic [6:0] c, input logic d);
        key_valid = 1'b1;
        key_code  = c;
        key_down  = d;
        tick();
        key_valid = 1'b0;
    endtask

    task automatic pop_exp(input string req, input int exp);
        chk(req, q_data, exp);
        q_pop = 1'b1;
        tick();
        q_pop = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 5; i++) tick();
    endtask

    task automatic drain();
        while (q_count != 0) begin
            q_pop = 1'b1;
            tick();
        end
        q_pop = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        // R1: reset state
        chk("R1 count", q_count, 0);
        chk("R1 busy", busy, 0);
        chk("R1 data", q_data, 0);

        // R2 R3 R4 R5: sweep every command byte over a queue holding 0x05
        for (int c = 0; c < 256; c++) begin
            key(7'h05, 1'b1);
            cmd(8'(c));
            settle();
            if (c == 8'h01) begin
                chk("R2 count", q_count, 3);
                pop_exp("R2 b0", 8'hFF);
                pop_exp("R2 b1", 8'h04);
                pop_exp("R2 b2", 8'h7F);
            end else if (c == 8'h07 || c == 8'h0F) begin
                chk("R3 count", q_count, 2);
                pop_exp("R3 b0", 8'hFE);
                pop_exp("R3 b1", 8'h21);
            end else begin
                chk("R5 count", q_count, 1);
                chk("R5 busy", busy, 0);
                pop_exp("R5 kept", 8'h05);
                if (c == 8'h0E) cmd(8'h00);
            end
            drain();
        end

        // R4: argument after 0x0E discarded even if it is a reply command
        cmd(8'h0E);
        cmd(8'h01);
        settle();
        chk("R4 arg skipped", q_count, 0);
        cmd(8'h01);
        settle();
        chk("R4 resumes", q_count, 3);
        drain();

        // R6: gating, and a gated byte does not use up the lighting argument
        tx_en = 1'b0;
        cmd(8'h01);
        settle();
        chk("R6 tx_en low", q_count, 0);
        tx_en = 1'b1;
        link_dis = 1'b1;
        cmd(8'h07);
        settle();
        chk("R6 link_dis", q_count, 0);
        link_dis = 1'b0;
        cmd(8'h0E);
        tx_en = 1'b0;
        cmd(8'h01);
        tx_en = 1'b1;
        cmd(8'h07);
        settle();
        chk("R6 arg kept pending", q_count, 0);
        cmd(8'h07);
        settle();
        chk("R6 after arg", q_count, 2);
        drain();

        // R7: timing of busy and one byte per clock, commands dropped while busy
        key(7'h11, 1'b1);
        key(7'h12, 1'b1);
        cmd(8'h01);
        chk("R7 busy up", busy, 1);
        chk("R7 cleared", q_count, 0);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h07;
        tick();
        chk("R7 one byte", q_count, 1);
        chk("R7 still busy", busy, 1);
        tick();
        chk("R7 two bytes", q_count, 2);
        tick();
        chk("R7 three bytes", q_count, 3);
        chk("R7 busy down", busy, 0);
        cmd_valid = 1'b0;
        settle();
        chk("R7 dropped cmd", q_count, 3);
        pop_exp("R7 b0", 8'hFF);
        pop_exp("R7 b1", 8'h04);
        pop_exp("R7 b2", 8'h7F);

        // R10: key preempts a reply byte
        cmd(8'h07);
        key(7'h10, 1'b1);
        chk("R10 key first", q_count, 1);
        tick();
        chk("R10 busy held", busy, 1);
        tick();
        chk("R10 busy down", busy, 0);
        pop_exp("R10 b0", 8'h10);
        pop_exp("R10 b1", 8'hFE);
        pop_exp("R10 b2", 8'h21);

        // R12: key in the accept cycle survives the clear
        key(7'h33, 1'b1);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h01;
        key_valid = 1'b1;
        key_code  = 7'h22;
        key_down  = 1'b1;
        tick();
        cmd_valid = 1'b0;
        key_valid = 1'b0;
        chk("R12 count", q_count, 1);
        settle();
        pop_exp("R12 b0", 8'h22);
        pop_exp("R12 b1", 8'hFF);
        pop_exp("R12 b2", 8'h04);
        pop_exp("R12 b3", 8'h7F);

        // R8: every non-lock keycode, press then release
        for (int c = 0; c < 128; c++) begin
            if (c == 8'h77 || c == 8'h62) continue;
            key(7'(c), 1'b1);
            key(7'(c), 1'b0);
            pop_exp("R8 make", c);
            pop_exp("R8 break", c | 8'h80);
        end

        // R9: interleaved lock keys, only alternate events sent
        key(7'h77, 1'b1);
        key(7'h62, 1'b1);
        key(7'h77, 1'b0);
        key(7'h62, 1'b0);
        key(7'h77, 1'b1);
        key(7'h62, 1'b1);
        key(7'h77, 1'b0);
        key(7'h62, 1'b0);
        chk("R9 count", q_count, 4);
        pop_exp("R9 caps on", 8'h77);
        pop_exp("R9 num on", 8'h62);
        pop_exp("R9 caps off", 8'hF7);
        pop_exp("R9 num off", 8'hE2);

        // R1: reset clears lock state, lighting argument and queue
        key(7'h77, 1'b1);
        key(7'h77, 1'b0);
        cmd(8'h0E);
        do_reset();
        chk("R1 queue cleared", q_count, 0);
        key(7'h77, 1'b1);
        chk("R1 lock state cleared", q_count, 1);
        pop_exp("R1 lock byte", 8'h77);
        cmd(8'h07);
        settle();
        chk("R1 arg state cleared", q_count, 2);
        drain();

        // R11: ordering, overflow, empty read, simultaneous push/pop
        for (int c = 1; c <= DEPTH + 2; c++) key(7'(c), 1'b1);
        chk("R11 full", q_count, DEPTH);
        for (int c = 1; c <= DEPTH; c++) pop_exp("R11 order", c);
        chk("R11 empty", q_count, 0);
        q_pop = 1'b1;
        tick();
        q_pop = 1'b0;
        chk("R11 empty pop count", q_count, 0);
        chk("R11 empty data", q_data, 0);
        key(7'h41, 1'b1);
        q_pop     = 1'b1;
        key_valid = 1'b1;
        key_code  = 7'h42;
        key_down  = 1'b1;
        tick();
        q_pop     = 1'b0;
        key_valid = 1'b0;
        chk("R11 push+pop count", q_count, 1);
        pop_exp("R11 push+pop data", 8'h42);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule